// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central scoreboard for a pipeline that issues in order and executes out of order across four functional units: integer, FP add, FP multiply and FP divide. Each cycle it makes four decisions. It decides whether the decoded instruction may enter a unit. It decides which units may fetch their operands from the register file. It decides which units may begin computing. It decides which finished units may commit their result. It keeps one status entry per unit and a result table with one entry per register, which names the unit that will write that register. The arithmetic, the register file and the fetch logic sit outside the block.

Hazards are resolved as late as correctness allows. A busy target unit (structural) or an owned destination register (WAW) stalls issue. A missing source value (RAW) holds only the consumer at operand read, so independent instructions keep moving. A pending anti-dependence (WAR) holds only the writer at write-back. The decode stage presents an instruction with `dec_valid` and treats it as taken in any cycle where `dec_stall` is low. Each unit's datapath watches `rd_grant`, `exec_start` and `wb_grant` and reports completion on `exec_done`.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `rd_grant`, `exec_start` and `wb_grant` are all zero and no register or unit is held, so the first valid instruction is accepted.
- R2: `dec_stall` is high when `dec_valid` is high and the unit selected by `dec_unit` (0 integer, 1 FP add, 2 FP multiply, 3 FP divide) is busy. A unit is busy from the edge that accepts its instruction until the edge that ends its write-back grant.
- R3: `dec_stall` is high when `dec_valid` is high and the destination register is still owned by an issued instruction whose write-back has not yet been granted.
- R4: An instruction is accepted at an edge where `dec_valid` is high and `dec_stall` is low. While its unit is busy, the operation code is presented on `fu_op` bits `[4*u+3:4*u]` for unit u.
- R5: `rd_grant[u]` is high for exactly one cycle. It is raised in the first cycle in which neither source of unit u has an outstanding producer. When the producer is granted write-back, that source counts as available from the next cycle. This also holds when the producer's write-back cycle is the consumer's issue cycle.
- R6: `exec_start[u]` is high for exactly the one cycle after `rd_grant[u]`.
- R7: `exec_done[u]` has an effect only after `exec_start[u]` and before the unit's write-back. A pulse at any other time is ignored.
- R8: A unit whose `exec_done` is sampled high requests write-back from the next cycle. `wb_grant[u]` is high in each cycle the request wins and is not held, and the grant ends the unit's instruction.
- R9: A requesting unit is held from write-back while any other busy unit has not yet read a source register equal to its destination and that source already has its value.
- R10: When more than one unit may write back, only the lowest-indexed one is granted. The others retry in later cycles.
- R11: A unit granted write-back may accept a new instruction in the next cycle, and its destination register is free in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_unit | input | 2 | Target functional unit index |
| dec_op | input | 4 | Operation code stored with the instruction |
| dec_dst | input | 4 | Destination register |
| dec_src1 | input | 4 | First source register |
| dec_src2 | input | 4 | Second source register |
| dec_stall | output | 1 | Instruction cannot be accepted this cycle |
| rd_grant | output | 4 | Per-unit operand-read permission |
| exec_start | output | 4 | Per-unit start-of-execution pulse |
| exec_done | input | 4 | Per-unit execution finished |
| wb_grant | output | 4 | Per-unit write-back permission |
| fu_op | output | 16 | Operation code held by each unit |

## Verification
The hardest case to reach from the ports is an issue that lands in the exact cycle its producer is granted write-back. In that cycle the result table still names the producer, and the producer's wake-up broadcast is happening at the same moment. The bench reaches this case by holding `dec_valid` low while its reference model steps the machine. When the model predicts the divide unit's grant for the current cycle, the bench presents the dependent instruction. A long-latency writer that is blocked by a reader, which in turn waits on another unit, covers the WAR hold in the same way.

// File: rtl/sb_pkg.sv
// Shared types for the scoreboard hazard control unit.
// Assumes: one state machine per functional unit walks these states in order.
package sb_pkg;

    typedef enum logic [2:0] {
        FU_IDLE     = 3'd0,   // no instruction held
        FU_WAIT_OPS = 3'd1,   // issued, waiting for both sources
        FU_START    = 3'd2,   // operands read, start pulse this cycle
        FU_EXEC     = 3'd3,   // datapath computing
        FU_WB       = 3'd4    // result ready, requesting write-back
    } fu_state_e;

endpackage

// File: rtl/sb_result_table.sv
// Register ownership table: one producer code per register, 0 meaning
// "no pending writer". Issue writes the issuing unit's code; write-back
// clears the entry. Assumes the two never target the same register in one
// cycle (issue requires the entry to be empty, a writer always owns its own).
module sb_result_table #(
    parameter int NUM_REG = 16,
    parameter int CODE_W  = 3,
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [REG_W-1:0]  set_reg,
    input  logic [CODE_W-1:0] set_code,
    input  logic              clr_en,
    input  logic [REG_W-1:0]  clr_reg,
    output logic [CODE_W-1:0] owner [NUM_REG]
);

    // Ownership update: claim on issue, release on write-back.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REG; r++) begin
            if (!rst_n) begin
                owner[r] <= '0;
            end else if (set_en && set_reg == REG_W'(r)) begin
                owner[r] <= set_code;
            end else if (clr_en && clr_reg == REG_W'(r)) begin
                owner[r] <= '0;
            end
        end
    end

endmodule

// File: rtl/sb_fu_slot.sv
// Status entry and sequencer for one functional unit. Holds the operation,
// destination, both sources, the producer code of each source and a flag
// per source meaning "value available but not yet read". The flags clear on
// the read, so a unit that has read no longer blocks a writer.
// Assumes: issue_en is raised only while the slot is idle.
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int OP_W   = 4,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  logic [OP_W-1:0]   op_in,
    input  logic [REG_W-1:0]  dst_in,
    input  logic [REG_W-1:0]  src1_in,
    input  logic [REG_W-1:0]  src2_in,
    input  logic [CODE_W-1:0] prod1_in,
    input  logic [CODE_W-1:0] prod2_in,
    input  logic [CODE_W-1:0] wb_code,
    input  logic              exec_done,
    input  logic              wb_win,
    output logic              busy,
    output logic [OP_W-1:0]   op_o,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  src1_o,
    output logic [REG_W-1:0]  src2_o,
    output logic              avail1_o,
    output logic              avail2_o,
    output logic              rd_grant,
    output logic              exec_start,
    output logic              wb_req
);

    fu_state_e         state;
    logic [CODE_W-1:0] prod1, prod2;
    logic              avail1, avail2;

    // Per-unit sequencing plus wake-up on a matching write-back broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FU_IDLE;
            op_o   <= '0;
            dst_o  <= '0;
            src1_o <= '0;
            src2_o <= '0;
            prod1  <= '0;
            prod2  <= '0;
            avail1 <= 1'b0;
            avail2 <= 1'b0;
        end else begin
            case (state)
                FU_IDLE: begin
                    if (issue_en) begin
                        op_o   <= op_in;
                        dst_o  <= dst_in;
                        src1_o <= src1_in;
                        src2_o <= src2_in;
                        prod1  <= prod1_in;
                        prod2  <= prod2_in;
                        avail1 <= (prod1_in == '0);
                        avail2 <= (prod2_in == '0);
                        state  <= FU_WAIT_OPS;
                    end
                end
                FU_WAIT_OPS: begin
                    if (rd_grant) begin
                        avail1 <= 1'b0;
                        avail2 <= 1'b0;
                        state  <= FU_START;
                    end else begin
                        if (wb_code != '0 && prod1 == wb_code) begin
                            prod1  <= '0;
                            avail1 <= 1'b1;
                        end
                        if (wb_code != '0 && prod2 == wb_code) begin
                            prod2  <= '0;
                            avail2 <= 1'b1;
                        end
                    end
                end
                FU_START: state <= FU_EXEC;
                FU_EXEC:  if (exec_done) state <= FU_WB;
                FU_WB:    if (wb_win) state <= FU_IDLE;
                default:  state <= FU_IDLE;
            endcase
        end
    end

    // Status decode.
    always_comb begin
        busy       = (state != FU_IDLE);
        rd_grant   = (state == FU_WAIT_OPS) && avail1 && avail2;
        exec_start = (state == FU_START);
        wb_req     = (state == FU_WB);
        avail1_o   = avail1;
        avail2_o   = avail2;
    end

endmodule

// File: rtl/sb_wb_arbiter.sv
// Fixed-priority write-back arbiter: the lowest index among eligible
// requesters wins. Assumes requests are already filtered for WAR holds.
module sb_wb_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic taken;

    // Pick the first set request bit from index 0 upward.
    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
// Scoreboard hazard control unit. Stalls issue on structural and WAW
// hazards, defers RAW to operand read and WAR to write-back. Unit u is
// known to the result table as code u+1, so code 0 means no producer.
// Assumes: the datapath reads operands in the rd_grant cycle and writes the
// register file in the wb_grant cycle.
module sb_hazard_ctrl #(
    parameter int  NUM_FU  = 4,
    parameter int  NUM_REG = 16,
    parameter int  OP_W    = 4,
    localparam int SEL_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int REG_W   = $clog2(NUM_REG),
    localparam int CODE_W  = $clog2(NUM_FU + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dec_valid,
    input  logic [SEL_W-1:0]       dec_unit,
    input  logic [OP_W-1:0]        dec_op,
    input  logic [REG_W-1:0]       dec_dst,
    input  logic [REG_W-1:0]       dec_src1,
    input  logic [REG_W-1:0]       dec_src2,
    output logic                   dec_stall,
    output logic [NUM_FU-1:0]      rd_grant,
    output logic [NUM_FU-1:0]      exec_start,
    input  logic [NUM_FU-1:0]      exec_done,
    output logic [NUM_FU-1:0]      wb_grant,
    output logic [NUM_FU*OP_W-1:0] fu_op
);

    logic [CODE_W-1:0] owner [NUM_REG];
    logic [NUM_FU-1:0] fu_busy, wb_req, war_hold, wb_ok, avail1, avail2;
    logic [REG_W-1:0]  fu_dst  [NUM_FU];
    logic [REG_W-1:0]  fu_src1 [NUM_FU];
    logic [REG_W-1:0]  fu_src2 [NUM_FU];
    logic [OP_W-1:0]   fu_opv  [NUM_FU];
    logic              issue_ok;
    logic [CODE_W-1:0] wb_code, prod1, prod2;
    logic [REG_W-1:0]  wb_reg;

    // Issue decision: structural and WAW checks only.
    always_comb begin
        issue_ok  = dec_valid && !fu_busy[dec_unit] && (owner[dec_dst] == '0);
        dec_stall = dec_valid && !issue_ok;
    end

    // Encode the write-back winner and its destination.
    always_comb begin
        wb_code = '0;
        wb_reg  = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (wb_grant[i]) begin
                wb_code = CODE_W'(i + 1);
                wb_reg  = fu_dst[i];
            end
        end
    end

    // Source producers at issue, with a producer writing back now treated as done.
    always_comb begin
        prod1 = (owner[dec_src1] == wb_code) ? '0 : owner[dec_src1];
        prod2 = (owner[dec_src2] == wb_code) ? '0 : owner[dec_src2];
    end

    // WAR hold: another unit still has an unread, available source equal to our destination.
    always_comb begin
        war_hold = '0;
        for (int w = 0; w < NUM_FU; w++) begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (u != w &&
                    ((avail1[u] && fu_src1[u] == fu_dst[w]) ||
                     (avail2[u] && fu_src2[u] == fu_dst[w]))) begin
                    war_hold[w] = 1'b1;
                end
            end
        end
        wb_ok = wb_req & ~war_hold;
    end

    sb_result_table #(
        .NUM_REG (NUM_REG),
        .CODE_W  (CODE_W)
    ) u_rtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_ok),
        .set_reg  (dec_dst),
        .set_code (CODE_W'(dec_unit) + CODE_W'(1)),
        .clr_en   (wb_code != '0),
        .clr_reg  (wb_reg),
        .owner    (owner)
    );

    sb_wb_arbiter #(
        .N (NUM_FU)
    ) u_arb (
        .req   (wb_ok),
        .grant (wb_grant)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
        sb_fu_slot #(
            .REG_W  (REG_W),
            .OP_W   (OP_W),
            .CODE_W (CODE_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_en   (issue_ok && (dec_unit == SEL_W'(g))),
            .op_in      (dec_op),
            .dst_in     (dec_dst),
            .src1_in    (dec_src1),
            .src2_in    (dec_src2),
            .prod1_in   (prod1),
            .prod2_in   (prod2),
            .wb_code    (wb_code),
            .exec_done  (exec_done[g]),
            .wb_win     (wb_grant[g]),
            .busy       (fu_busy[g]),
            .op_o       (fu_opv[g]),
            .dst_o      (fu_dst[g]),
            .src1_o     (fu_src1[g]),
            .src2_o     (fu_src2[g]),
            .avail1_o   (avail1[g]),
            .avail2_o   (avail2[g]),
            .rd_grant   (rd_grant[g]),
            .exec_start (exec_start[g]),
            .wb_req     (wb_req[g])
        );
        assign fu_op[g*OP_W +: OP_W] = fu_opv[g];
    end

endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
// Protocol checker for the scoreboard hazard control unit, bound to the top.
// Assumes: reset is synchronous and active low.
module sb_hazard_ctrl_chk #(
    parameter int NUM_FU = 4,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [SEL_W-1:0]  dec_unit,
    input logic              dec_stall,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] exec_start,
    input logic [NUM_FU-1:0] wb_grant,
    input logic [NUM_FU-1:0] fu_busy
);

    p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    p_busy_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && fu_busy[dec_unit]) |-> dec_stall);

    for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
        p_start_follows_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> exec_start[g]);

        p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            exec_start[g] |=> !exec_start[g]);

        p_read_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> !rd_grant[g]);

        p_free_after_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[g] |=> !fu_busy[g]);

        p_read_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |-> fu_busy[g]);
    end

endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk #(
    .NUM_FU (NUM_FU),
    .SEL_W  (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_unit   (dec_unit),
    .dec_stall  (dec_stall),
    .rd_grant   (rd_grant),
    .exec_start (exec_start),
    .wb_grant   (wb_grant),
    .fu_busy    (fu_busy)
);

// File: tb/sb_hazard_ctrl_test.sv
`timescale 1ns/1ps
// Bench for the scoreboard hazard control unit: a behavioural reference
// model steps alongside the design and every output is compared each cycle.
module sb_hazard_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [1:0]  dec_unit = '0;
    logic [3:0]  dec_op = '0, dec_dst = '0, dec_src1 = '0, dec_src2 = '0;
    logic        dec_stall;
    logic [3:0]  rd_grant, exec_start, wb_grant;
    logic [3:0]  exec_done = '0;
    logic [15:0] fu_op;

    always #4 clk = ~clk;   // 125 MHz

    sb_hazard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
        .dec_op(dec_op), .dec_dst(dec_dst), .dec_src1(dec_src1), .dec_src2(dec_src2),
        .dec_stall(dec_stall), .rd_grant(rd_grant), .exec_start(exec_start),
        .exec_done(exec_done), .wb_grant(wb_grant), .fu_op(fu_op)
    );

    typedef struct {int unit; int op; int dst; int s1; int s2; int lat;} ins_t;
    ins_t q[$];

    // Reference model state: 0 idle, 1 waiting operands, 2 start, 3 exec, 4 write-back.
    int m_st[4], m_dst[4], m_s1[4], m_s2[4], m_p1[4], m_p2[4], m_op[4], m_lat[4], m_done_at[4];
    int m_own[16];
    bit spur_mark[4];
    int cyc = 0, errors = 0, checks = 0, last_wb = -1;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    function automatic bit m_war(input int w);
        for (int u = 0; u < 4; u++)
            if (u != w && m_st[u] == 1 &&
                ((m_p1[u] < 0 && m_s1[u] == m_dst[w]) || (m_p2[u] < 0 && m_s2[u] == m_dst[w])))
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_pred_wb();
        for (int w = 0; w < 4; w++)
            if (m_st[w] == 4 && !m_war(w)) return w;
        return -1;
    endfunction

    task automatic step(input logic [3:0] spur);
        ins_t h;
        bit v, stall_e, iss;
        bit erd[4];
        int wbu, p1, p2;
        string tg;
        v = (q.size() != 0);
        h = v ? q[0] : '{0, 0, 0, 0, 0, 1};
        dec_valid = v;
        dec_unit  = 2'(h.unit);
        dec_op    = 4'(h.op);
        dec_dst   = 4'(h.dst);
        dec_src1  = 4'(h.s1);
        dec_src2  = 4'(h.s2);
        for (int u = 0; u < 4; u++) begin
            exec_done[u] = spur[u] | (m_st[u] == 3 && cyc >= m_done_at[u]);
            if (spur[u] && m_st[u] != 3) spur_mark[u] = 1'b1;
        end
        #1;
        wbu     = m_pred_wb();
        stall_e = v && (m_st[h.unit] != 0 || m_own[h.dst] >= 0);
        if (v) begin
            tg = (m_st[h.unit] != 0) ? "R2" : (m_own[h.dst] >= 0) ? "R3" :
                 (last_wb == h.unit) ? "R11" : "R4";
            chk(dec_stall == stall_e, tg, "dec_stall", dec_stall, stall_e);
        end
        for (int u = 0; u < 4; u++) begin
            erd[u] = (m_st[u] == 1 && m_p1[u] < 0 && m_p2[u] < 0);
            chk(rd_grant[u] == erd[u], "R5", $sformatf("rd_grant[%0d]", u), rd_grant[u], erd[u]);
            chk(exec_start[u] == (m_st[u] == 2), "R6", $sformatf("exec_start[%0d]", u),
                exec_start[u], m_st[u] == 2);
            tg = spur_mark[u] ? "R7" : (m_st[u] == 4 && m_war(u)) ? "R9" :
                 (m_st[u] == 4 && wbu != u) ? "R10" : "R8";
            chk(wb_grant[u] == (wbu == u), tg, $sformatf("wb_grant[%0d]", u), wb_grant[u], wbu == u);
            if (m_st[u] != 0)
                chk(int'(fu_op[u*4 +: 4]) == m_op[u], "R4", $sformatf("fu_op[%0d]", u),
                    fu_op[u*4 +: 4], m_op[u]);
        end
        // Advance the model.
        iss = v && !stall_e;
        p1 = (iss && m_own[h.s1] == wbu) ? -1 : m_own[h.s1];
        p2 = (iss && m_own[h.s2] == wbu) ? -1 : m_own[h.s2];
        for (int u = 0; u < 4; u++) begin
            case (m_st[u])
                1: if (erd[u]) m_st[u] = 2;
                2: begin m_st[u] = 3; m_done_at[u] = cyc + m_lat[u]; end
                3: if (exec_done[u]) m_st[u] = 4;
                default: ;
            endcase
        end
        if (wbu >= 0) begin
            m_st[wbu] = 0;
            m_own[m_dst[wbu]] = -1;
            spur_mark[wbu] = 1'b0;
            for (int u = 0; u < 4; u++) begin
                if (m_p1[u] == wbu) m_p1[u] = -1;
                if (m_p2[u] == wbu) m_p2[u] = -1;
            end
        end
        if (iss) begin
            m_st[h.unit] = 1;  m_op[h.unit] = h.op;   m_dst[h.unit] = h.dst;
            m_s1[h.unit] = h.s1; m_s2[h.unit] = h.s2; m_lat[h.unit] = h.lat;
            m_p1[h.unit] = p1; m_p2[h.unit] = p2;
            m_own[h.dst] = h.unit;
            void'(q.pop_front());
        end
        last_wb = wbu;
        cyc++;
        @(negedge clk);
    endtask

    task automatic push(input int unit, input int op, input int dst, input int s1, input int s2, input int lat);
        q.push_back('{unit, op, dst, s1, s2, lat});
    endtask

    task automatic drain();
        int n = 0;
        bit idle;
        do begin
            step(4'b0000);
            n++;
            idle = (q.size() == 0);
            for (int u = 0; u < 4; u++) if (m_st[u] != 0) idle = 1'b0;
        end while (!idle && n < 300);
        chk(idle, "R8", "drain", n, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R8", "watchdog", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 4; u++) begin
            m_st[u] = 0; m_p1[u] = -1; m_p2[u] = -1; spur_mark[u] = 1'b0;
        end
        for (int r = 0; r < 16; r++) m_own[r] = -1;
        exec_done = 4'b1111;                       // ignored while in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        exec_done = '0;
        #1;
        chk(rd_grant == 0, "R1", "rd_grant in reset", rd_grant, 0);
        chk(exec_start == 0, "R1", "exec_start in reset", exec_start, 0);
        chk(wb_grant == 0, "R1", "wb_grant in reset", wb_grant, 0);
        chk(dec_stall == 0, "R1", "dec_stall in reset", dec_stall, 0);
        rst_n = 1'b1;

        // Independent instructions on separate units (R4, R5, R6, R8).
        push(1, 3, 1, 2, 3, 2);
        push(2, 5, 4, 5, 6, 3);
        drain();

        // RAW: add waits for divide; spurious done pulses on waiting and idle units (R5, R7).
        push(3, 9, 1, 2, 3, 6);
        push(1, 4, 4, 1, 5, 2);
        step(4'b0000);
        step(4'b0000);
        step(4'b0110);
        step(4'b0001);
        drain();

        // WAW: integer op targets a register the multiplier owns (R3).
        push(2, 6, 2, 1, 3, 4);
        push(0, 1, 2, 4, 5, 1);
        drain();

        // Structural: two adds back to back; second issues after first write-back (R2, R11).
        push(1, 7, 7, 1, 2, 2);
        push(1, 8, 8, 3, 4, 1);
        drain();

        // WAR: multiply writes R8 that a blocked add has yet to read (R9).
        push(3, 10, 0, 2, 4, 6);
        push(1, 11, 6, 0, 8, 2);
        push(2, 12, 8, 1, 3, 1);
        drain();

        // Simultaneous completion of integer and add units (R10).
        push(0, 13, 10, 1, 1, 3);
        push(1, 14, 11, 2, 2, 2);
        drain();

        // Same-cycle issue and producer write-back (R5 bypass).
        push(3, 15, 12, 1, 2, 3);
        for (int n = 0; n < 50 && m_pred_wb() != 3; n++) step(4'b0000);
        push(1, 2, 13, 12, 12, 1);
        drain();

        summary();
        $finish;
    end

endmodule